// File: doc/BRIEF.md
# Fractional-N divide ratio sequencer

This block sits in the feedback path of a synthesizer loop. It runs on the output clock of a dual-modulus prescaler, where each rising edge is one prescaler output. For every divided cycle it tells the prescaler when to divide by P+1 and when to divide by P. It also marks the end of the divided cycle with a pulse that goes to the phase detector.

A pulse-swallow pair of counters sets the integer part of the ratio. A divided cycle lasts B prescaler outputs, and the first S of them use P+1. A first-order fractional accumulator adds the numerator FN once per divided cycle. The accumulator wraps at a modulus that is not a power of two: 1920 or 1968, picked by a reference-select pin, so that one numerator step is always 10 kHz of output frequency. When the accumulator wraps, that cycle swallows one extra prescaler output (S = A + 1 instead of A). Over time the average divide ratio comes to P*B + A + FN/M.

Configuration pins are sampled only at divided-cycle boundaries. A value outside the legal range is clamped to the nearest legal value and flagged. The prescaler, oscillator, phase detector and loop filter are outside this block. All pins are plain control and status signals, with no handshake.

Top module: `frac_div_seq`

## Requirements
- R1: While `rst_n` is low, `mod_ctl`, `div_pulse` and `cfg_err` are 0 and the accumulator is cleared. The first rising clock edge after release is a priming edge that loads the configuration, and the first divided cycle begins after it.
- R2: Each divided cycle lasts exactly B_eff prescaler clocks. `div_pulse` is high for one clock, on the last clock of each divided cycle.
- R3: Within a divided cycle, `mod_ctl` (1 = divide by P+1) is high on the first S clocks and low on the rest. S is A_eff plus the accumulator carry of that cycle.
- R4: On each boundary the accumulator adds FN_eff. When the sum is at least M, it subtracts M and produces a carry. Over any M consecutive divided cycles, the number of carries equals FN_eff.
- R5: M is 1920 when `ref_sel` = 0 and 1968 when `ref_sel` = 1.
- R6: `pre_sel` = 1 selects P = 8, with a swallow limit of 7. `pre_sel` = 0 selects P = 6, with a swallow limit of 5.
- R7: Changes to `cnt_b`, `swal_a`, `frac_num`, `pre_sel` and `ref_sel` in the middle of a divided cycle do not affect that cycle. Only the values present at the edge that ends a cycle (or at the priming edge) are used, and they apply to the next cycle.
- R8: The clamp rules are:
  - B below 2 becomes 2.
  - A above the swallow limit becomes the limit.
  - A at or above B_eff becomes B_eff-1.
  - FN at or above M becomes M-1.
  
  `cfg_err` is 1 for exactly those divided cycles whose loaded fields needed clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock; one rising edge per prescaler output |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_b | input | 4 | Divided-cycle length B (legal 2..15) |
| swal_a | input | 3 | Base swallow count A |
| frac_num | input | 11 | Fractional numerator FN |
| pre_sel | input | 1 | Prescaler value select: 1 = 8, 0 = 6 |
| ref_sel | input | 1 | Modulus select: 0 = 1920, 1 = 1968 |
| mod_ctl | output | 1 | 1 = prescaler divides by P+1 for the current output |
| div_pulse | output | 1 | High on the last prescaler clock of a divided cycle |
| cfg_err | output | 1 | Fields of the current divided cycle were clamped |

## Verification
Two long runs check the average ratio:
- A run of 1920 cycles with `ref_sel` = 0.
- A run of 1968 cycles with `ref_sel` = 1, using a numerator between 1920 and 1967.

The second run is legal only under the larger modulus, so a wrong modulus choice shows up as a wrong carry total or a spurious error flag. Shorter runs cover the remaining cases:
- Each swallow limit at its edge for both prescaler values.
- Each clamp rule on its own.
- FN = 0, where no carry may appear.
- B = 2, where the swallow count can fill the whole cycle.

Every cycle, the inputs are overwritten with junk in mid-cycle and restored before the boundary, which separates correct boundary sampling from continuous sampling.

// File: rtl/fds_pkg.sv
package fds_pkg;

  // Prescaler value selection carried on the pre_sel pin.
  typedef enum logic {
    PRE_SMALL = 1'b0,
    PRE_LARGE = 1'b1
  } pre_mode_e;

  // Default geometry of the sequencer.
  localparam int FDS_BW     = 4;
  localparam int FDS_AW     = 3;
  localparam int FDS_FW     = 11;
  localparam int FDS_MOD_LO = 1920;
  localparam int FDS_MOD_HI = 1968;
  localparam int FDS_PRE_HI = 8;
  localparam int FDS_PRE_LO = 6;
  localparam int FDS_B_MIN  = 2;

endpackage

// File: rtl/fds_field_clamp.sv
module fds_field_clamp
  import fds_pkg::*;
#(
  parameter int BW     = FDS_BW,
  parameter int AW     = FDS_AW,
  parameter int FW     = FDS_FW,
  parameter int MOD_LO = FDS_MOD_LO,
  parameter int MOD_HI = FDS_MOD_HI,
  parameter int PRE_HI = FDS_PRE_HI,
  parameter int PRE_LO = FDS_PRE_LO,
  parameter int B_MIN  = FDS_B_MIN
) (
  input  logic [BW-1:0] b_in,
  input  logic [AW-1:0] a_in,
  input  logic [FW-1:0] fn_in,
  input  logic          pre_sel,
  input  logic          ref_sel,
  output logic [BW-1:0] b_eff,
  output logic [AW-1:0] a_eff,
  output logic [FW-1:0] fn_eff,
  output logic [FW-1:0] modulus,
  output logic          err
);

  localparam int CW = ((BW > AW) ? BW : AW) + 1;
  localparam logic [AW-1:0] A_LIM_LARGE = AW'(PRE_HI - 1);
  localparam logic [AW-1:0] A_LIM_SMALL = AW'(PRE_LO - 1);

  logic [AW-1:0] a_lim;
  logic [CW-1:0] a_x, lim_x, cap_x, pick_x;
  logic          b_low, a_over_lim, a_over_cap, fn_over;

  always_comb begin
    // Cycle length lower bound
    b_low  = (b_in < BW'(B_MIN));
    b_eff  = b_low ? BW'(B_MIN) : b_in;

    // Swallow count bound: prescaler limit and cycle length
    a_lim  = (pre_mode_e'(pre_sel) == PRE_LARGE) ? A_LIM_LARGE : A_LIM_SMALL;
    a_x    = CW'(a_in);
    lim_x  = CW'(a_lim);
    cap_x  = CW'(b_eff) - CW'(1);
    a_over_lim = (a_x > lim_x);
    a_over_cap = (a_x > cap_x);
    pick_x = a_x;
    if (a_over_lim) pick_x = lim_x;
    if (pick_x > cap_x) pick_x = cap_x;
    a_eff  = AW'(pick_x);

    // Modulus and numerator bound
    modulus = ref_sel ? FW'(MOD_HI) : FW'(MOD_LO);
    fn_over = (fn_in >= modulus);
    fn_eff  = fn_over ? (modulus - FW'(1)) : fn_in;

    err = b_low | a_over_lim | a_over_cap | fn_over;
  end

endmodule

// File: rtl/fds_frac_accum.sv
module fds_frac_accum #(
  parameter int FW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [FW-1:0] fn,
  input  logic [FW-1:0] modulus,
  output logic [FW-1:0] acc_q,
  output logic [FW-1:0] acc_nxt,
  output logic          carry
);

  localparam int SW = FW + 1;

  logic [SW-1:0] sum;
  logic [SW-1:0] wrapped;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, fn};
    carry   = (sum >= {1'b0, modulus});
    wrapped = sum - {1'b0, modulus};
    acc_nxt = carry ? wrapped[FW-1:0] : sum[FW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= acc_nxt;
  end

endmodule

// File: rtl/fds_swallow_seq.sv
module fds_swallow_seq #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] len_load,
  input  logic [BW-1:0] swal_load,
  output logic          boundary,
  output logic          mod_ctl,
  output logic          div_pulse
);

  logic [BW-1:0] cnt_q, len_q, swal_q;
  logic          primed_q;
  logic          at_end;

  always_comb begin
    at_end    = (cnt_q == (len_q - BW'(1)));
    boundary  = !primed_q || at_end;
    div_pulse = primed_q && at_end;
    mod_ctl   = primed_q && (cnt_q < swal_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      len_q    <= '1;
      swal_q   <= '0;
      primed_q <= 1'b0;
    end else if (boundary) begin
      cnt_q    <= '0;
      len_q    <= len_load;
      swal_q   <= swal_load;
      primed_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + BW'(1);
    end
  end

endmodule

// File: rtl/frac_div_seq.sv
module frac_div_seq
  import fds_pkg::*;
#(
  parameter int BW     = FDS_BW,
  parameter int AW     = FDS_AW,
  parameter int FW     = FDS_FW,
  parameter int MOD_LO = FDS_MOD_LO,
  parameter int MOD_HI = FDS_MOD_HI,
  parameter int PRE_HI = FDS_PRE_HI,
  parameter int PRE_LO = FDS_PRE_LO,
  parameter int B_MIN  = FDS_B_MIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] cnt_b,
  input  logic [AW-1:0] swal_a,
  input  logic [FW-1:0] frac_num,
  input  logic          pre_sel,
  input  logic          ref_sel,
  output logic          mod_ctl,
  output logic          div_pulse,
  output logic          cfg_err
);

  logic [BW-1:0] b_eff;
  logic [AW-1:0] a_eff;
  logic [FW-1:0] fn_eff;
  logic [FW-1:0] modulus;
  logic          err;
  logic [FW-1:0] acc_q;
  logic [FW-1:0] acc_nxt;
  logic          carry;
  logic          boundary;
  logic [BW-1:0] swal_load;

  fds_field_clamp #(
    .BW(BW), .AW(AW), .FW(FW), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI),
    .PRE_HI(PRE_HI), .PRE_LO(PRE_LO), .B_MIN(B_MIN)
  ) clamp_i (
    .b_in    (cnt_b),
    .a_in    (swal_a),
    .fn_in   (frac_num),
    .pre_sel (pre_sel),
    .ref_sel (ref_sel),
    .b_eff   (b_eff),
    .a_eff   (a_eff),
    .fn_eff  (fn_eff),
    .modulus (modulus),
    .err     (err)
  );

  fds_frac_accum #(.FW(FW)) accum_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (boundary),
    .fn      (fn_eff),
    .modulus (modulus),
    .acc_q   (acc_q),
    .acc_nxt (acc_nxt),
    .carry   (carry)
  );

  // Swallow count for the next cycle: base count plus this boundary's carry
  assign swal_load = BW'(a_eff) + BW'(carry);

  fds_swallow_seq #(.BW(BW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_load  (b_eff),
    .swal_load (swal_load),
    .boundary  (boundary),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_err <= 1'b0;
    else if (boundary) cfg_err <= err;
  end

endmodule

// File: rtl/fds_chk.sv
module fds_chk #(
  parameter int BW     = 4,
  parameter int AW     = 3,
  parameter int FW     = 11,
  parameter int PRE_HI = 8,
  parameter int PRE_LO = 6,
  parameter int B_MIN  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_ctl,
  input logic          div_pulse,
  input logic          cfg_err,
  input logic          pre_sel,
  input logic [BW-1:0] b_eff,
  input logic [AW-1:0] a_eff,
  input logic [FW-1:0] fn_eff,
  input logic [FW-1:0] modulus,
  input logic [FW-1:0] acc_q,
  input logic [FW-1:0] acc_nxt,
  input logic          carry
);

  localparam logic [BW:0] GAP_LO = (BW+1)'(B_MIN);
  localparam logic [BW:0] GAP_HI = (BW+1)'((2**BW) - 1);

  logic [1:0]  since_q;
  logic [BW:0] gap_q;
  logic        seen_q;
  logic        done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      gap_q   <= '0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (since_q != 2'd3) since_q <= since_q + 2'd1;
      if (div_pulse)       gap_q   <= (BW+1)'(1);
      else if (gap_q != '1) gap_q  <= gap_q + (BW+1)'(1);
      seen_q <= seen_q | div_pulse;
      if (div_pulse || since_q == 2'd0) done_q <= 1'b0;
      else if (!mod_ctl)                done_q <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == 2'd0) |-> (!div_pulse && !mod_ctl));

  // R2
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && seen_q) |-> (gap_q >= GAP_LO && gap_q <= GAP_HI));

  // R3
  mod_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !mod_ctl);

  // R4
  acc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (acc_nxt < acc_q));

  // R4
  acc_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !carry |-> (acc_nxt >= acc_q));

  // R6
  a_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (a_eff <= (pre_sel ? AW'(PRE_HI - 1) : AW'(PRE_LO - 1))));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 2'd2 && !$stable(cfg_err)) |-> $past(div_pulse));

  // R8
  clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (b_eff >= BW'(B_MIN) && BW'(a_eff) < b_eff && fn_eff < modulus));

endmodule

bind frac_div_seq fds_chk #(
  .BW(BW), .AW(AW), .FW(FW), .PRE_HI(PRE_HI), .PRE_LO(PRE_LO), .B_MIN(B_MIN)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mod_ctl   (mod_ctl),
  .div_pulse (div_pulse),
  .cfg_err   (cfg_err),
  .pre_sel   (pre_sel),
  .b_eff     (b_eff),
  .a_eff     (a_eff),
  .fn_eff    (fn_eff),
  .modulus   (modulus),
  .acc_q     (acc_q),
  .acc_nxt   (acc_nxt),
  .carry     (carry)
);

// File: tb/frac_div_seq_tb_top.sv
module frac_div_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cnt_b = 4'd0;
  logic [2:0]  swal_a = 3'd0;
  logic [10:0] frac_num = 11'd0;
  logic        pre_sel = 1'b0;
  logic        ref_sel = 1'b0;
  logic        mod_ctl, div_pulse, cfg_err;

  int checks = 0;
  int failures = 0;
  int pushed = 0;
  int popped = 0;
  int m_acc = 0;
  int carries[6];
  bit done = 1'b0;

  typedef struct {
    int len;
    int swal;
    int a_base;
    bit err;
    int phase;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  frac_div_seq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_b     (cnt_b),
    .swal_a    (swal_a),
    .frac_num  (frac_num),
    .pre_sel   (pre_sel),
    .ref_sel   (ref_sel),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse),
    .cfg_err   (cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle's fields and push the cycle expected from the requirements
  task automatic apply(input int b, input int a, input int fn,
                       input bit p8, input bit rs, input int ph);
    exp_t e;
    int be, al, ae, m, fe, sum;
    bit c, er;
    cnt_b = 4'(b); swal_a = 3'(a); frac_num = 11'(fn);
    pre_sel = p8; ref_sel = rs;
    be = (b < 2) ? 2 : b;
    al = p8 ? 7 : 5;
    ae = a;
    if (ae > al) ae = al;
    if (ae > be - 1) ae = be - 1;
    m  = rs ? 1968 : 1920;
    fe = (fn >= m) ? m - 1 : fn;
    er = (b < 2) || (a > al) || (a > be - 1) || (fn >= m);
    sum = m_acc + fe;
    c = (sum >= m);
    m_acc = c ? sum - m : sum;
    e.len = be; e.swal = ae + int'(c); e.a_base = ae; e.err = er; e.phase = ph;
    exp_q.push_back(e);
    pushed++;
  endtask

  // R7: scramble inputs in mid-cycle, then wait for the cycle's last clock
  task automatic to_boundary();
    @(negedge clk);
    if (!div_pulse) begin
      cnt_b = ~cnt_b; swal_a = ~swal_a; frac_num = frac_num ^ 11'h5A5;
      pre_sel = ~pre_sel; ref_sel = ~ref_sel;
    end
    while (!div_pulse) @(negedge clk);
  endtask

  task automatic run(input int n, input int b, input int a, input int fn,
                     input bit p8, input bit rs, input int ph);
    for (int i = 0; i < n; i++) begin
      apply(b, a, fn, p8, rs, ph);
      to_boundary();
    end
  endtask

  // Monitor: compares each observed divided cycle against the queue head
  int  mon_pos = 0;
  int  mon_swal = 0;
  bit  mon_contig = 1'b1;
  exp_t mon_e;

  initial begin
    wait (rst_n);
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (done) break;
      if (exp_q.size() != 0) begin
        mon_e = exp_q[0];
        if (mod_ctl != (mon_pos < mon_e.swal)) mon_contig = 1'b0;
        mon_swal += int'(mod_ctl);
        mon_pos++;
        if (div_pulse) begin
          void'(exp_q.pop_front());
          popped++;
          check(mon_pos == mon_e.len, "R2,R7", "divided cycle length", mon_pos, mon_e.len);
          check(mon_swal == mon_e.swal, "R3,R7", "P+1 selections in cycle", mon_swal, mon_e.swal);
          check(mon_contig, "R3", "P+1 run placed at cycle start", int'(mon_contig), 1);
          check(cfg_err == mon_e.err, "R8", "cfg_err for cycle", int'(cfg_err), int'(mon_e.err));
          carries[mon_e.phase] += mon_swal - mon_e.a_base;
          mon_pos = 0; mon_swal = 0; mon_contig = 1'b1;
        end
      end
    end
  end

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", popped, pushed);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) carries[i] = 0;
    // R1: quiet outputs while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!mod_ctl, "R1", "mod_ctl in reset", int'(mod_ctl), 0);
      check(!div_pulse, "R1", "div_pulse in reset", int'(div_pulse), 0);
      check(!cfg_err, "R1", "cfg_err in reset", int'(cfg_err), 0);
    end
    // Phase 0, R4: one full modulus period with the 1920 modulus
    apply(11, 4, 1104, 1'b1, 1'b0, 0);
    rst_n = 1'b1;
    to_boundary();
    run(1919, 11, 4, 1104, 1'b1, 1'b0, 0);
    // Phase 1, R5: numerator legal only under the 1968 modulus
    run(1968, 9, 3, 1930, 1'b0, 1'b1, 1);
    // Phase 2, R6: swallow limits of both prescaler values
    run(20, 10, 7, 500, 1'b1, 1'b0, 2);
    run(20, 10, 7, 500, 1'b0, 1'b0, 2);
    run(20, 10, 5, 37, 1'b0, 1'b0, 2);
    // Phase 3, R8: each clamp rule alone, then all together
    run(10, 1, 0, 0, 1'b0, 1'b0, 3);
    run(10, 4, 6, 300, 1'b1, 1'b0, 3);
    run(30, 6, 2, 2000, 1'b1, 1'b0, 3);
    run(10, 6, 2, 1967, 1'b1, 1'b1, 3);
    run(10, 0, 7, 2047, 1'b0, 1'b0, 3);
    // Phase 4, R4: zero numerator gives no carry
    run(50, 15, 0, 0, 1'b1, 1'b0, 4);
    // Phase 5: shortest cycle, swallow may fill it
    run(40, 2, 1, 1919, 1'b1, 1'b0, 5);
    @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    check(popped == pushed, "R2", "divided cycles observed", popped, pushed);
    check(carries[0] == 1104, "R4", "carries over 1920 cycles", carries[0], 1104);
    check(carries[1] == 1930, "R5", "carries over 1968 cycles", carries[1], 1930);
    check(carries[4] == 0, "R4", "carries with zero numerator", carries[4], 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule